// File: doc/BRIEF.md
# Cycle-Stealing Single-Channel DMA Engine

This block is a one-channel direct memory access engine that shares one address and data bus with a processor. A request arrives either from software, by a register write, or from the rising edge of an interrupt line. When the channel is enabled, the request raises a bus request toward the arbiter. After the grant arrives, the engine does one read and then one write, and returns the bus at once. Each request takes exactly one transfer of one byte or one 16-bit word.

One pointer is fixed. The other, called the forward pointer, is a working copy of either the source or the destination base. It advances after every transfer. A 16-bit live counter is loaded from a reload value and counts transfers down. When it runs out, the channel either disables itself or reloads the counter and the forward pointer from their bases and keeps running. A request that arrives while an earlier request is still waiting is merged into it, so there can be fewer transfers than requests.

Register write port, selected by `reg_addr`:
- 0: source base, 20 bits.
- 1: destination base, 20 bits.
- 2: reload value, bits 15:0.
- 3: control register, with these bits:
  - bit 0: enable.
  - bit 1: word size (1 = 16-bit word, 0 = byte).
  - bit 2: forward select (1 = the destination advances, 0 = the source advances).
  - bit 3: repeat.
  - bit 4: interrupt source select.
- 4: software request (a write with bit 0 = 1).

Top module: `cs_dma`

## Requirements
- R1: After reset, `bus_req`, `mem_rd`, `mem_wr` and `chan_on` are all 0.
- R2: A write to address 3 with bit 0 = 1 sets `chan_on`, loads the live counter from the reload value and loads the forward pointer from the base it follows.
- R3: While bit 0 of the control register is 0, a software request or interrupt edge is ignored: no bus request follows.
- R4: A request raises `bus_req`. No memory access happens until `bus_gnt` is 1. Then there is one `mem_rd` cycle followed directly by one `mem_wr` cycle, and `bus_req` falls in the next cycle.
- R5: The read uses the source address and the write uses the destination address. The written data is the data returned for the read, which arrives in the cycle after `mem_rd`.
- R6: The forward pointer advances by 1 after a byte transfer and by 2 after a word transfer. `mem_word` shows control bit 1.
- R7: With control bit 2 = 1, the destination address advances while the source stays fixed. With bit 2 = 0, the reverse holds.
- R8: Without repeat, `chan_on` clears in the cycle after the write that brings the counter to zero. The counter counts reload transfers, and a reload value of 0 means 65536 transfers.
- R9: With repeat (control bit 3 = 1), the channel stays enabled when the counter runs out. It reloads the counter, and the forward pointer restarts at its base.
- R10: One pending flag holds requests. It is cleared when the grant starts the transfer. Requests that arrive while it is set are lost.
- R11: An interrupt request is the rising edge of `irq_in`, and it is taken only when control bit 4 = 1. A level held high gives one request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 20 | Register write data |
| irq_in | input | 1 | Interrupt request line |
| bus_req | output | 1 | Bus request to arbiter |
| bus_gnt | input | 1 | Bus grant from arbiter |
| mem_addr | output | 20 | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_word | output | 1 | Transfer size, 1 = word |
| mem_rdata | input | 16 | Read data, valid the cycle after mem_rd |
| mem_wdata | output | 16 | Write data |
| chan_on | output | 1 | Channel enable state |

## Verification
The assertions assume that once the arbiter grants the bus, it keeps `bus_gnt` high until `bus_req` falls. They also assume the memory returns read data in exactly the cycle after `mem_rd`. The bench meets both assumptions by driving the grant as the bus request ANDed with an allow flag. That flag changes only while no transfer is in progress. The bench memory model uses a registered read port. Register writes and requests are spaced so that none of them falls in the same cycle as a grant starting a transfer.

// File: rtl/cs_dma_pkg.sv
package cs_dma_pkg;

    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] A_SRC  = 3'd0;
    localparam logic [REG_AW-1:0] A_DST  = 3'd1;
    localparam logic [REG_AW-1:0] A_RLD  = 3'd2;
    localparam logic [REG_AW-1:0] A_CTL  = 3'd3;
    localparam logic [REG_AW-1:0] A_SREQ = 3'd4;

    typedef struct packed {
        logic irq_sel;
        logic rep;
        logic fwd_dst;
        logic word;
        logic en;
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_RD   = 2'd2,
        ST_WR   = 2'd3
    } state_t;

    function automatic logic [1:0] fwd_step(input logic word);
        return word ? 2'd2 : 2'd1;
    endfunction

endpackage

// File: rtl/cs_dma_regs.sv
module cs_dma_regs
    import cs_dma_pkg::*;
#(
    parameter int AW = 20,
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [AW-1:0]     wr_data,
    input  logic              xfer_done,
    output ctrl_t             ctrl,
    output logic [AW-1:0]     rd_ptr,
    output logic [AW-1:0]     wr_ptr
);
    localparam int CTL_W = $bits(ctrl_t);

    logic [AW-1:0] src_base, dst_base, fwd;
    logic [CW-1:0] reload, cnt;
    ctrl_t         ctl_new;
    logic [AW-1:0] step_ext;

    assign ctl_new  = ctrl_t'(wr_data[CTL_W-1:0]);
    assign step_ext = {{(AW-2){1'b0}}, fwd_step(ctrl.word)};

    always_ff @(posedge clk) begin
        if (rst) begin
            src_base <= '0;
            dst_base <= '0;
            fwd      <= '0;
            reload   <= '0;
            cnt      <= '0;
            ctrl     <= '0;
        end else begin
            if (xfer_done) begin
                if (cnt == CW'(1)) begin
                    if (ctrl.rep) begin
                        cnt <= reload;
                        fwd <= ctrl.fwd_dst ? dst_base : src_base;
                    end else begin
                        cnt     <= '0;
                        fwd     <= fwd + step_ext;
                        ctrl.en <= 1'b0;
                    end
                end else begin
                    cnt <= cnt - CW'(1);
                    fwd <= fwd + step_ext;
                end
            end
            if (wr_en) begin
                case (wr_addr)
                    A_SRC: src_base <= wr_data;
                    A_DST: dst_base <= wr_data;
                    A_RLD: reload   <= wr_data[CW-1:0];
                    A_CTL: begin
                        ctrl <= ctl_new;
                        if (ctl_new.en) begin
                            cnt <= reload;
                            fwd <= ctl_new.fwd_dst ? dst_base : src_base;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rd_ptr = ctrl.fwd_dst ? src_base : fwd;
    assign wr_ptr = ctrl.fwd_dst ? fwd : dst_base;

endmodule

// File: rtl/cs_dma_req.sv
module cs_dma_req
    import cs_dma_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [AW-1:0]     wr_data,
    input  logic              irq_in,
    input  ctrl_t             ctrl,
    input  logic              take,
    output logic              pend
);
    logic irq_q;
    logic soft_hit, irq_edge, new_req;

    assign soft_hit = wr_en && (wr_addr == A_SREQ) && wr_data[0];
    assign irq_edge = irq_in && !irq_q && ctrl.irq_sel;
    assign new_req  = (soft_hit || irq_edge) && ctrl.en;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
            pend  <= 1'b0;
        end else begin
            irq_q <= irq_in;
            if (!ctrl.en) pend <= 1'b0;
            else          pend <= (pend && !take) || new_req;
        end
    end

endmodule

// File: rtl/cs_dma_seq.sv
module cs_dma_seq
    import cs_dma_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pend,
    input  logic en,
    input  logic gnt,
    output logic take,
    output logic breq,
    output logic rd,
    output logic wr
);
    state_t st;

    assign take = (st == ST_REQ) && gnt;
    assign breq = (st != ST_IDLE);
    assign rd   = (st == ST_RD);
    assign wr   = (st == ST_WR);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE: if (pend && en) st <= ST_REQ;
                ST_REQ:  if (gnt)        st <= ST_RD;
                ST_RD:                   st <= ST_WR;
                ST_WR:                   st <= ST_IDLE;
                default:                 st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cs_dma.sv
module cs_dma
    import cs_dma_pkg::*;
#(
    parameter int AW = 20,
    parameter int CW = 16,
    parameter int DW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [AW-1:0]     reg_wdata,
    input  logic              irq_in,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              mem_word,
    input  logic [DW-1:0]     mem_rdata,
    output logic [DW-1:0]     mem_wdata,
    output logic              chan_on
);
    ctrl_t         ctrl;
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic          pend, take;

    cs_dma_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(reg_wr_en), .wr_addr(reg_addr), .wr_data(reg_wdata),
        .xfer_done(mem_wr),
        .ctrl(ctrl), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr)
    );

    cs_dma_req #(.AW(AW)) u_req (
        .clk(clk), .rst(rst),
        .wr_en(reg_wr_en), .wr_addr(reg_addr), .wr_data(reg_wdata),
        .irq_in(irq_in), .ctrl(ctrl), .take(take), .pend(pend)
    );

    cs_dma_seq u_seq (
        .clk(clk), .rst(rst), .pend(pend), .en(ctrl.en), .gnt(bus_gnt),
        .take(take), .breq(bus_req), .rd(mem_rd), .wr(mem_wr)
    );

    assign mem_addr  = mem_wr ? wr_ptr : rd_ptr;
    assign mem_wdata = mem_rdata;
    assign mem_word  = ctrl.word;
    assign chan_on   = ctrl.en;

endmodule

// File: rtl/cs_dma_chk.sv
module cs_dma_chk (
    input logic clk,
    input logic rst,
    input logic reg_wr_en,
    input logic bus_req,
    input logic bus_gnt,
    input logic mem_rd,
    input logic mem_wr,
    input logic chan_on
);
    // R4
    rd_needs_grant_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> (bus_req && bus_gnt));

    // R4
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> mem_wr);

    // R4
    no_rd_wr_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R4
    release_after_wr_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> !bus_req);

    // R8
    off_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(chan_on) |-> ($past(mem_wr) || $past(reg_wr_en)));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!bus_req && !mem_rd && !mem_wr && !chan_on));

endmodule

bind cs_dma cs_dma_chk u_chk (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .mem_rd(mem_rd), .mem_wr(mem_wr), .chan_on(chan_on)
);

// File: tb/sim_cs_dma.sv
`timescale 1ns/1ps
module sim_cs_dma;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [19:0] reg_wdata = '0;
    logic        irq_in = 1'b0;
    logic        bus_req, bus_gnt, mem_rd, mem_wr, mem_word, chan_on;
    logic [19:0] mem_addr;
    logic [15:0] mem_rdata, mem_wdata;
    logic        allow = 1'b1;

    int errors = 0;
    int checks = 0;
    int wr_total = 0;
    int rd_total = 0;
    logic [19:0] wr_addr_log [0:31];
    logic [15:0] wr_data_log [0:31];
    logic [19:0] rd_addr_log [0:31];
    logic        word_log    [0:31];

    always #2 clk = ~clk;

    assign bus_gnt = bus_req && allow;

    cs_dma u0 (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .irq_in(irq_in), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_word(mem_word), .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata), .chan_on(chan_on)
    );

    // memory model: registered read, contents 0xA000 + low address byte
    always @(posedge clk) begin
        if (mem_rd) begin
            mem_rdata <= 16'hA000 + {8'h00, mem_addr[7:0]};
            if (rd_total < 32) rd_addr_log[rd_total] <= mem_addr;
            rd_total <= rd_total + 1;
        end
        if (mem_wr) begin
            if (wr_total < 32) begin
                wr_addr_log[wr_total] <= mem_addr;
                wr_data_log[wr_total] <= mem_wdata;
                word_log[wr_total]    <= mem_word;
            end
            wr_total <= wr_total + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] a, input logic [19:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_writes(input int target);
        for (int i = 0; i < 200 && wr_total < target; i++) @(negedge clk);
        idle(2);
    endtask

    task automatic t_reset;
        check("R1 bus_req", bus_req, 0);
        check("R1 mem_rd", mem_rd, 0);
        check("R1 mem_wr", mem_wr, 0);
        check("R1 chan_on", chan_on, 0);
    endtask

    task automatic t_word_src;
        int b;
        b = wr_total;
        wreg(3'd0, 20'h10010);
        wreg(3'd1, 20'h20000);
        wreg(3'd2, 20'd3);
        wreg(3'd3, 20'b00011);
        check("R2 chan_on set", chan_on, 1);
        for (int k = 0; k < 3; k++) begin
            wreg(3'd4, 20'd1);
            wait_writes(b + k + 1);
        end
        check("R4 one write per request", wr_total - b, 3);
        for (int k = 0; k < 3; k++) begin
            check("R5 dst fixed", wr_addr_log[b+k], 20'h20000);
            check("R6 word step data", wr_data_log[b+k], 16'hA010 + 16'(2*k));
            check("R6 mem_word", word_log[b+k], 1);
        end
        check("R8 channel off after count", chan_on, 0);
        wreg(3'd4, 20'd1);
        idle(10);
        check("R3 request after auto-off ignored", wr_total - b, 3);
    endtask

    task automatic t_byte_dst;
        int b;
        b = wr_total;
        wreg(3'd0, 20'h00005);
        wreg(3'd1, 20'h30040);
        wreg(3'd2, 20'd2);
        wreg(3'd3, 20'b00101);
        wreg(3'd4, 20'd1);
        wait_writes(b + 1);
        wreg(3'd4, 20'd1);
        wait_writes(b + 2);
        check("R7 dst advances 0", wr_addr_log[b], 20'h30040);
        check("R7 dst advances by 1 (R6)", wr_addr_log[b+1], 20'h30041);
        check("R7 src fixed", wr_data_log[b+1], 16'hA005);
        check("R6 byte size", word_log[b], 0);
        check("R8 off after two", chan_on, 0);
    endtask

    task automatic t_disabled;
        int b;
        b = wr_total;
        wreg(3'd3, 20'b00000);
        wreg(3'd4, 20'd1);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (bus_req) begin
                check("R3 no bus_req while disabled", bus_req, 0);
                break;
            end
        end
        check("R3 no transfer while disabled", wr_total - b, 0);
    endtask

    task automatic t_grant;
        int b;
        int early;
        b = wr_total;
        early = 0;
        allow = 1'b0;
        wreg(3'd0, 20'h00020);
        wreg(3'd1, 20'h50000);
        wreg(3'd2, 20'd4);
        wreg(3'd3, 20'b00011);
        wreg(3'd4, 20'd1);
        idle(3);
        check("R4 bus_req raised", bus_req, 1);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (mem_rd || mem_wr) early++;
        end
        check("R4 no access before grant", early, 0);
        allow = 1'b1;
        wait_writes(b + 1);
        check("R4 transfer after grant", wr_total - b, 1);
        check("R4 bus released", bus_req, 0);
        check("R5 read addr", rd_addr_log[rd_total-1], 20'h00020);
    endtask

    task automatic t_merge;
        int b;
        b = wr_total;
        allow = 1'b0;
        wreg(3'd4, 20'd1);
        wreg(3'd4, 20'd1);
        wreg(3'd4, 20'd1);
        idle(3);
        allow = 1'b1;
        idle(20);
        check("R10 merged requests", wr_total - b, 1);
        check("R10 still enabled", chan_on, 1);
    endtask

    task automatic t_repeat;
        int b;
        b = rd_total;
        wreg(3'd0, 20'h00040);
        wreg(3'd1, 20'h60000);
        wreg(3'd2, 20'd2);
        wreg(3'd3, 20'b01011);
        for (int k = 0; k < 3; k++) begin
            wreg(3'd4, 20'd1);
            wait_writes(wr_total + 1);
        end
        check("R9 read 0", rd_addr_log[b], 20'h00040);
        check("R9 read 1", rd_addr_log[b+1], 20'h00042);
        check("R9 read 2 restarts", rd_addr_log[b+2], 20'h00040);
        check("R9 stays enabled", chan_on, 1);
    endtask

    task automatic t_irq;
        int b;
        b = wr_total;
        wreg(3'd2, 20'd10);
        wreg(3'd3, 20'b00011);
        @(negedge clk) irq_in = 1'b1;
        idle(3);
        irq_in = 1'b0;
        idle(15);
        check("R11 irq ignored when unselected", wr_total - b, 0);
        wreg(3'd3, 20'b10011);
        @(negedge clk) irq_in = 1'b1;
        idle(25);
        check("R11 held level gives one transfer", wr_total - b, 1);
        irq_in = 1'b0;
        idle(2);
        @(negedge clk) irq_in = 1'b1;
        @(negedge clk) irq_in = 1'b0;
        wait_writes(b + 2);
        check("R11 second edge", wr_total - b, 2);
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle(3);
        t_reset();
        @(negedge clk) rst = 1'b0;
        idle(2);
        t_reset();
        t_word_src();
        t_byte_dst();
        t_disabled();
        t_grant();
        t_merge();
        t_repeat();
        t_irq();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule